// File: doc/BRIEF.md
# Return-Flag Instruction Decoder and Sequencer

This block sits at the front of a small two-stack CPU that has no operand fields in its instructions. Each cycle it takes one 9-bit word from instruction memory, together with the current program counter and the value on top of the return stack. It returns the next program counter, the controls for the return stack and the data stack, a literal byte, and an operation index for the ALU datapath. The low eight bits form the opcode byte. The ninth bit comes from the memory's spare parity lane. On ordinary opcodes that leave the return stack alone, this bit folds a subroutine return into the same instruction and cycle. On the literal, jump and call opcodes it becomes one more immediate bit.

Opcode byte layout:
- `0lllllll`: literal. The 8-bit payload `{bit8, lllllll}` is shifted into the top of the return stack.
- `1000dddd`: relative jump.
- `1001dddd`: relative call. The signed 5-bit offset `{bit8, dddd}` is added to PC+1.
- `11nnnnnn`: operation number n. Numbers 0 to 18 accept the return flag. Numbers 19 to 32 work on the return stack themselves. All other codes are undefined.

A two-state machine sequences the block. ST_BOOT is entered on reset. Its outputs are quiet and the next PC is the reset vector, because the memory word is not valid yet. The transition BOOT_TO_RUN happens on the first clock edge after reset is released. ST_RUN then decodes every word. Its only transition is RUN_HOLD, back to itself, until the next reset.

Top module: `retflag_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pc_next` equals RESET_PC (default 0). In those cycles every stack control, `op_valid`, `ret_merged`, `lit_value` and `op_code` is 0, whatever the instruction word holds.
- R2: Operations 0 to 18 (byte `11nnnnnn`) with bit 8 clear give `pc_next` = PC+1, `op_valid`=1 and `op_code`=n. Numbers 0 to 7 and 17 to 18 assert `ds_pop`. Numbers 14 to 16 assert `ds_push`. Numbers 8 to 13 touch neither stack.
- R3: Operations 0 to 18 with bit 8 set keep the data-stack effect of R2. They also assert `ret_merged` and `rs_pop`, and give `pc_next` = `rs_top`, all in the same cycle.
- R4: A jump `1000dddd` gives `pc_next` = PC + 1 + sign-extended `{bit8,dddd}`. The offset covers -16 to +15. No stack control is raised.
- R5: A call `1001dddd` computes the same target as a jump. It asserts `rs_push` with `rs_push_from_ds`=0, and `ret_addr` = PC+1.
- R6: A literal `0lllllll` asserts `rs_shift` and gives `lit_value` = `{bit8,lllllll}` and `pc_next` = PC+1. `lit_value` is 0 for every other opcode.
- R7: Operation 19 is an explicit return. It gives `pc_next` = `rs_top` and `rs_pop`=1, with `ret_merged`=0.
- R8: Operation 20 asserts `rs_push`, `rs_push_from_ds` and `ds_pop`. Operation 21 asserts `rs_pop` and `ds_push`. Operation 22 asserts `ds_push`. Operation 23 asserts `rs_pop`. Operations 24 to 32 assert only `op_valid`. All of 20 to 32 advance to PC+1.
- R9: Undefined codes (`11nnnnnn` with n above 32, and `1010xxxx` or `1011xxxx`) raise no control. They give `op_valid`=0, `op_code`=0 and `pc_next` = PC+1.
- R10: All program-counter arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 9 | Instruction word; bit 8 is the extra flag or immediate bit |
| pc | input | PC_W | Address of the current instruction |
| rs_top | input | PC_W | Current top of the return stack |
| pc_next | output | PC_W | Address to fetch next |
| ret_addr | output | PC_W | Link address (PC+1) to push on a call |
| rs_push | output | 1 | Push onto the return stack |
| rs_push_from_ds | output | 1 | Push source is the data-stack top rather than `ret_addr` |
| rs_pop | output | 1 | Pop the return stack |
| rs_shift | output | 1 | Shift `lit_value` into the return-stack top |
| lit_value | output | 8 | Literal payload |
| ds_push | output | 1 | Data stack grows by one |
| ds_pop | output | 1 | Data stack shrinks by one |
| op_valid | output | 1 | A defined operation is issued to the datapath |
| op_code | output | 6 | Operation number for the datapath |
| ret_merged | output | 1 | A return was folded into this instruction |

## Verification
The assertions assume that software never sets bit 8 on a return-stack operation (19 to 32) or on an undefined code, because the bit has no meaning there. The stimulus table therefore uses bit 8 only on operations 0 to 18, literals, jumps and calls. The boot and mid-run reset tests drive a flagged eligible operation, so the BOOT quieting is seen to override a word that would otherwise trigger a return. The corner cases cover both ends of the offset range, a jump to itself, and PC wrap at the top of the address space.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int WORD_W = 9;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 6;
    localparam int OFF_W  = 5;

    // operation-number boundaries inside the 11nnnnnn space
    localparam logic [IDX_W-1:0] OP_BIN_LAST   = 6'd7;
    localparam logic [IDX_W-1:0] OP_UNARY_LAST = 6'd13;
    localparam logic [IDX_W-1:0] OP_PUSH_LAST  = 6'd16;
    localparam logic [IDX_W-1:0] OP_ELIG_LAST  = 6'd18;
    localparam logic [IDX_W-1:0] OP_RET        = 6'd19;
    localparam logic [IDX_W-1:0] OP_TO_R       = 6'd20;
    localparam logic [IDX_W-1:0] OP_FROM_R     = 6'd21;
    localparam logic [IDX_W-1:0] OP_R_COPY     = 6'd22;
    localparam logic [IDX_W-1:0] OP_R_DROP     = 6'd23;
    localparam logic [IDX_W-1:0] OP_LAST       = 6'd32;

    typedef enum logic [2:0] {
        CL_PLAIN,
        CL_RSOP,
        CL_JUMP,
        CL_CALL,
        CL_LIT,
        CL_UNDEF
    } iclass_e;

    typedef enum logic [1:0] {
        PCS_INC,
        PCS_REL,
        PCS_RSTOP,
        PCS_BOOT
    } pcsel_e;

    typedef enum logic {
        ST_BOOT,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/rfs_classify.sv
module rfs_classify
    import rfs_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    output iclass_e           cls,
    output logic [IDX_W-1:0]  idx,
    output logic              ds_push,
    output logic              ds_pop,
    output logic              rs_push_ds,
    output logic              rs_pop_op,
    output logic              is_ret
);

    always_comb begin
        cls        = CL_UNDEF;
        idx        = op_byte[IDX_W-1:0];
        ds_push    = 1'b0;
        ds_pop     = 1'b0;
        rs_push_ds = 1'b0;
        rs_pop_op  = 1'b0;
        is_ret     = 1'b0;

        if (!op_byte[7]) begin
            cls = CL_LIT;
        end else if (op_byte[6]) begin
            if (idx <= OP_ELIG_LAST)      cls = CL_PLAIN;
            else if (idx <= OP_LAST)      cls = CL_RSOP;
        end else if (op_byte[5:4] == 2'b00) begin
            cls = CL_JUMP;
        end else if (op_byte[5:4] == 2'b01) begin
            cls = CL_CALL;
        end

        unique case (cls)
            CL_PLAIN: begin
                if (idx <= OP_BIN_LAST)        ds_pop  = 1'b1;
                else if (idx <= OP_UNARY_LAST) ds_pop  = 1'b0;
                else if (idx <= OP_PUSH_LAST)  ds_push = 1'b1;
                else                           ds_pop  = 1'b1;
            end
            CL_RSOP: begin
                if (idx == OP_RET) begin
                    is_ret    = 1'b1;
                    rs_pop_op = 1'b1;
                end else if (idx == OP_TO_R) begin
                    rs_push_ds = 1'b1;
                    ds_pop     = 1'b1;
                end else if (idx == OP_FROM_R) begin
                    rs_pop_op = 1'b1;
                    ds_push   = 1'b1;
                end else if (idx == OP_R_COPY) begin
                    ds_push = 1'b1;
                end else if (idx == OP_R_DROP) begin
                    rs_pop_op = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/rfs_immed.sv
module rfs_immed
    import rfs_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic [WORD_W-1:0] instr,
    output logic [PC_W-1:0]   offset,
    output logic [BYTE_W-1:0] lit
);

    localparam int EXT_W = PC_W - OFF_W;

    logic [OFF_W-1:0] off_raw;

    // the spare bit becomes the sign of the relative offset
    assign off_raw = {instr[8], instr[3:0]};

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset = {{EXT_W{off_raw[OFF_W-1]}}, off_raw};
        end else begin : g_trunc
            assign offset = off_raw[PC_W-1:0];
        end
    endgenerate

    // the spare bit becomes the top bit of the literal payload
    assign lit = {instr[8], instr[6:0]};

endmodule

// File: rtl/rfs_pcsel.sv
module rfs_pcsel
    import rfs_pkg::*;
#(
    parameter int               PC_W     = 10,
    parameter logic [PC_W-1:0]  RESET_PC = '0
) (
    input  pcsel_e          sel,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] offset,
    input  logic [PC_W-1:0] rs_top,
    output logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] pc_inc
);

    assign pc_inc = pc + PC_W'(1);

    always_comb begin
        unique case (sel)
            PCS_INC:   pc_next = pc_inc;
            PCS_REL:   pc_next = pc_inc + offset;
            PCS_RSTOP: pc_next = rs_top;
            PCS_BOOT:  pc_next = RESET_PC;
            default:   pc_next = RESET_PC;
        endcase
    end

endmodule

// File: rtl/retflag_sequencer.sv
module retflag_sequencer
    import rfs_pkg::*;
#(
    parameter int               PC_W     = 10,
    parameter logic [PC_W-1:0]  RESET_PC = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   instr,
    input  logic [PC_W-1:0]     pc,
    input  logic [PC_W-1:0]     rs_top,
    output logic [PC_W-1:0]     pc_next,
    output logic [PC_W-1:0]     ret_addr,
    output logic                rs_push,
    output logic                rs_push_from_ds,
    output logic                rs_pop,
    output logic                rs_shift,
    output logic [BYTE_W-1:0]   lit_value,
    output logic                ds_push,
    output logic                ds_pop,
    output logic                op_valid,
    output logic [IDX_W-1:0]    op_code,
    output logic                ret_merged
);

    seq_state_e state_q, state_d;

    iclass_e           cls;
    logic [IDX_W-1:0]  idx;
    logic              c_ds_push, c_ds_pop, c_rs_push_ds, c_rs_pop, c_is_ret;
    logic [PC_W-1:0]   offset;
    logic [BYTE_W-1:0] lit_raw;
    pcsel_e            pc_sel;
    logic              ret_flag;

    assign ret_flag = instr[8];

    rfs_classify u_classify (
        .op_byte    (instr[BYTE_W-1:0]),
        .cls        (cls),
        .idx        (idx),
        .ds_push    (c_ds_push),
        .ds_pop     (c_ds_pop),
        .rs_push_ds (c_rs_push_ds),
        .rs_pop_op  (c_rs_pop),
        .is_ret     (c_is_ret)
    );

    rfs_immed #(.PC_W(PC_W)) u_immed (
        .instr  (instr),
        .offset (offset),
        .lit    (lit_raw)
    );

    rfs_pcsel #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcsel (
        .sel     (pc_sel),
        .pc      (pc),
        .offset  (offset),
        .rs_top  (rs_top),
        .pc_next (pc_next),
        .pc_inc  (ret_addr)
    );

    // next-state logic: BOOT_TO_RUN, then RUN_HOLD
    always_comb begin
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        pc_sel          = PCS_BOOT;
        rs_push         = 1'b0;
        rs_push_from_ds = 1'b0;
        rs_pop          = 1'b0;
        rs_shift        = 1'b0;
        lit_value       = '0;
        ds_push         = 1'b0;
        ds_pop          = 1'b0;
        op_valid        = 1'b0;
        op_code         = '0;
        ret_merged      = 1'b0;

        unique case (state_q)
            ST_BOOT: begin
                pc_sel = PCS_BOOT;
            end
            ST_RUN: begin
                pc_sel = PCS_INC;
                unique case (cls)
                    CL_PLAIN: begin
                        op_valid = 1'b1;
                        op_code  = idx;
                        ds_push  = c_ds_push;
                        ds_pop   = c_ds_pop;
                        if (ret_flag) begin
                            ret_merged = 1'b1;
                            rs_pop     = 1'b1;
                            pc_sel     = PCS_RSTOP;
                        end
                    end
                    CL_RSOP: begin
                        op_valid        = 1'b1;
                        op_code         = idx;
                        ds_push         = c_ds_push;
                        ds_pop          = c_ds_pop;
                        rs_push         = c_rs_push_ds;
                        rs_push_from_ds = c_rs_push_ds;
                        rs_pop          = c_rs_pop;
                        if (c_is_ret) pc_sel = PCS_RSTOP;
                    end
                    CL_JUMP: begin
                        pc_sel = PCS_REL;
                    end
                    CL_CALL: begin
                        pc_sel  = PCS_REL;
                        rs_push = 1'b1;
                    end
                    CL_LIT: begin
                        rs_shift  = 1'b1;
                        lit_value = lit_raw;
                    end
                    default: begin
                    end
                endcase
            end
            default: begin
            end
        endcase
    end

    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> (pc_next == RESET_PC && !rs_push && !rs_pop && !rs_shift
                                  && !ds_push && !ds_pop && !op_valid)); // R1

    AST_MERGE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_merged |-> (rs_pop && !rs_push && !rs_shift && pc_next == rs_top)); // R3

    AST_ONE_RS_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rs_push, rs_pop, rs_shift}) <= 1); // R3

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_push && !rs_push_from_ds) |-> (ret_addr == pc + PC_W'(1) && !ds_push && !ds_pop)); // R5

    AST_LIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lit_value != '0) |-> rs_shift); // R6

    AST_NO_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && (cls == CL_RSOP || cls == CL_UNDEF)) |-> !instr[8]); // R7

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cls == CL_UNDEF) |-> (!op_valid && pc_next == pc + PC_W'(1))); // R9

endmodule

// File: tb/retflag_sequencer_test.sv
module retflag_sequencer_test;

    localparam int PC_W = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [8:0]      instr;
    logic [PC_W-1:0] pc, rs_top;
    logic [PC_W-1:0] pc_next, ret_addr;
    logic            rs_push, rs_push_from_ds, rs_pop, rs_shift;
    logic [7:0]      lit_value;
    logic            ds_push, ds_pop, op_valid, ret_merged;
    logic [5:0]      op_code;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    retflag_sequencer #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .rs_top(rs_top),
        .pc_next(pc_next), .ret_addr(ret_addr), .rs_push(rs_push),
        .rs_push_from_ds(rs_push_from_ds), .rs_pop(rs_pop), .rs_shift(rs_shift),
        .lit_value(lit_value), .ds_push(ds_push), .ds_pop(ds_pop),
        .op_valid(op_valid), .op_code(op_code), .ret_merged(ret_merged)
    );

    // {merged, rs_push, rs_pop, rs_shift, rs_from_ds, ds_push, ds_pop, op_valid}
    function automatic logic [7:0] flags();
        return {ret_merged, rs_push, rs_pop, rs_shift, rs_push_from_ds, ds_push, ds_pop, op_valid};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // {req, instr, pc, rs_top, exp_pc_next, exp_flags, exp_lit, exp_op_code}
    localparam int VW = 4 + 9 + 10 + 10 + 10 + 8 + 8 + 6;
    localparam int NV = 23;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2,  9'h0C0, 10'h100, 10'h2A5, 10'h101, 8'h03, 8'h00, 6'd0 },  // R2 binary
        {4'd3,  9'h1C0, 10'h100, 10'h2A5, 10'h2A5, 8'hA3, 8'h00, 6'd0 },  // R3 binary + return
        {4'd2,  9'h0CA, 10'h100, 10'h2A5, 10'h101, 8'h01, 8'h00, 6'd10},  // R2 unary
        {4'd3,  9'h1CF, 10'h100, 10'h2A5, 10'h2A5, 8'hA5, 8'h00, 6'd15},  // R3 push + return
        {4'd3,  9'h1D2, 10'h100, 10'h2A5, 10'h2A5, 8'hA3, 8'h00, 6'd18},  // R3 last eligible
        {4'd7,  9'h0D3, 10'h100, 10'h2A5, 10'h2A5, 8'h21, 8'h00, 6'd19},  // R7 explicit return
        {4'd8,  9'h0D4, 10'h100, 10'h2A5, 10'h101, 8'h4B, 8'h00, 6'd20},  // R8 to return stack
        {4'd8,  9'h0D5, 10'h100, 10'h2A5, 10'h101, 8'h25, 8'h00, 6'd21},  // R8 from return stack
        {4'd8,  9'h0D6, 10'h100, 10'h2A5, 10'h101, 8'h05, 8'h00, 6'd22},  // R8 copy
        {4'd8,  9'h0D7, 10'h100, 10'h2A5, 10'h101, 8'h21, 8'h00, 6'd23},  // R8 drop
        {4'd8,  9'h0E0, 10'h100, 10'h2A5, 10'h101, 8'h01, 8'h00, 6'd32},  // R8 in-place op
        {4'd9,  9'h0E1, 10'h100, 10'h2A5, 10'h101, 8'h00, 8'h00, 6'd0 },  // R9 number 33
        {4'd9,  9'h0A5, 10'h100, 10'h2A5, 10'h101, 8'h00, 8'h00, 6'd0 },  // R9 1010 space
        {4'd4,  9'h083, 10'h100, 10'h2A5, 10'h104, 8'h00, 8'h00, 6'd0 },  // R4 +3
        {4'd4,  9'h08F, 10'h100, 10'h2A5, 10'h110, 8'h00, 8'h00, 6'd0 },  // R4 +15
        {4'd4,  9'h180, 10'h100, 10'h2A5, 10'h0F1, 8'h00, 8'h00, 6'd0 },  // R4 -16
        {4'd4,  9'h18F, 10'h100, 10'h2A5, 10'h100, 8'h00, 8'h00, 6'd0 },  // R4 -1, to itself
        {4'd5,  9'h095, 10'h100, 10'h2A5, 10'h106, 8'h40, 8'h00, 6'd0 },  // R5 call +5
        {4'd5,  9'h19C, 10'h100, 10'h2A5, 10'h0FD, 8'h40, 8'h00, 6'd0 },  // R5 call -4
        {4'd6,  9'h17F, 10'h100, 10'h2A5, 10'h101, 8'h10, 8'hFF, 6'd0 },  // R6 literal 0xFF
        {4'd6,  9'h12A, 10'h100, 10'h2A5, 10'h101, 8'h10, 8'hAA, 6'd0 },  // R6 literal 0xAA
        {4'd10, 9'h08F, 10'h3FF, 10'h2A5, 10'h00F, 8'h00, 8'h00, 6'd0 },  // R10 jump wraps
        {4'd10, 9'h0C9, 10'h3FF, 10'h2A5, 10'h000, 8'h01, 8'h00, 6'd9 }   // R10 increment wraps
    };

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        instr  = 9'h1C0;   // flagged eligible op: would return if decoded
        pc     = 10'h100;
        rs_top = 10'h2A5;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "pc_next in reset", 32'(pc_next), 32'h000);
        chk("R1", "flags in reset", 32'(flags()), 32'h00);
        chk("R1", "op_code in reset", 32'(op_code), 32'h00);

        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "pc_next boot cycle", 32'(pc_next), 32'h000);
        chk("R1", "flags boot cycle", 32'(flags()), 32'h00);

        @(negedge clk);
        #1;
        chk("R3", "pc_next first run", 32'(pc_next), 32'h2A5);
        chk("R3", "flags first run", 32'(flags()), 32'hA3);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[64:61], i);
            @(negedge clk);
            instr  = v[60:52];
            pc     = v[51:42];
            rs_top = v[41:32];
            #1;
            chk(tag, "pc_next", 32'(pc_next), 32'(v[31:22]));
            chk(tag, "flags", 32'(flags()), 32'(v[21:14]));
            chk(tag, "lit_value", 32'(lit_value), 32'(v[13:6]));
            chk(tag, "op_code", 32'(op_code), 32'(v[5:0]));
        end

        // R5: link address is PC+1
        @(negedge clk);
        instr = 9'h091;
        pc    = 10'h200;
        #1;
        chk("R5", "ret_addr", 32'(ret_addr), 32'h201);
        chk("R5", "call target", 32'(pc_next), 32'h202);

        // R1: reset in the middle of a run quiets the block at once
        @(negedge clk);
        instr = 9'h1C0;
        rs_top = 10'h155;
        rst_n = 1'b0;
        #1;
        chk("R1", "pc_next mid-run reset", 32'(pc_next), 32'h000);
        chk("R1", "flags mid-run reset", 32'(flags()), 32'h00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "boot after re-reset", 32'(pc_next), 32'h000);
        @(negedge clk);
        #1;
        chk("R3", "return after re-reset", 32'(pc_next), 32'h155);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule